// File: doc/BRIEF.md
# Response Frame Transmit Controller

This block builds every frame that leaves the device toward an Ethernet MAC in answer to host traffic. A frame parser hands it two kinds of work. A read request names a virtual channel and a serial number. The controller points the channel select at that channel and issues a one-cycle fetch command to a channel fetch engine. It then waits until the engine reports completion with a byte count. An acknowledge request carries a serial number, a channel and a size, and it becomes a header-only frame that echoes those values back.

No byte goes to the MAC until the MAC has granted the controller's transmit request. After the grant the frame is sent one byte per cycle with no gaps, and the MAC applies no back-pressure. The 14-byte header has three parts. The first six bytes are a fixed host address. The next six bytes hold the control header: serial number, frame type, channel and flags, and size. The last two bytes are a fixed protocol code. A read that fetched data then streams its payload from a first-word-fall-through FIFO. A marker on the final byte tells the MAC where to append its CRC. A read that fetched nothing is answered with a Null frame instead.

If an acknowledge arrives while a read response is in flight, it is parked and sent straight after that frame. New read requests are refused until the controller is idle with no acknowledge waiting.

Top module: `rsp_tx_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, `tx_valid`, `tx_last`, `mac_req`, `fetch_start` and `fifo_rd` are low. After reset `rd_ready` is high.
- R2: A read is accepted on a clock edge where `rd_valid` and `rd_ready` are both high. In the next cycle `vc_sel` equals the requested channel and `fetch_start` is high for exactly one cycle.
- R3: While waiting for `fetch_done`, the block keeps `mac_req`, `tx_valid` and `rd_ready` low. A `rd_valid` seen while busy is not accepted: it causes no new `fetch_start` and leaves `vc_sel` unchanged.
- R4: In the cycle after `fetch_done`, `mac_req` is high. It stays high with `tx_valid` low until a cycle in which `mac_gnt` is high.
- R5: The cycle after a grant, the header begins and is sent one byte per cycle with no gap. Bytes 0-5 are the host address, most significant byte first. Bytes 6-7 are the serial number, high byte first. Byte 8 is the frame type. Byte 9 holds the channel in bits 7:6 and the flags in bits 3:0. Bytes 10-11 are the size, high byte first. Bytes 12-13 are the protocol code.
- R6: A fetch count of zero gives a Null frame: type 0x00, flags 0x0, size 0, 14 bytes only, and no `fifo_rd`.
- R7: A nonzero fetch count N gives a Write frame: type 0x02, flags 0x3 (start bit 0 plus end bit 1), size N. The header is followed by N payload bytes taken from `fifo_data`, with `fifo_rd` high on exactly those N byte cycles.
- R8: An acknowledge request gives a 14-byte frame of type 0x05 with flags 0x0, carrying the acknowledge's serial number, channel and size.
- R9: An acknowledge that arrives during a read response is held and sent as the next frame. While an acknowledge is pending, `rd_ready` is low.
- R10: `tx_last` is high only together with `tx_valid`, exactly once per frame, on its final byte: byte 13 for header-only frames and the last payload byte for Write frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_valid | input | 1 | Read request present |
| rd_ready | output | 1 | Read request can be accepted |
| rd_serial | input | 16 | Serial number of the read request |
| rd_chan | input | 2 | Virtual channel of the read request |
| ack_valid | input | 1 | Acknowledge request strobe |
| ack_serial | input | 16 | Serial number to echo |
| ack_chan | input | 2 | Channel to echo |
| ack_size | input | 16 | Size to echo |
| vc_sel | output | 2 | Channel select toward the fetch multiplexer |
| fetch_start | output | 1 | One-cycle fetch command |
| fetch_done | input | 1 | Fetch engine completion strobe |
| fetch_count | input | CNT_W | Bytes placed in the FIFO |
| fifo_rd | output | 1 | Pop the FIFO head |
| fifo_data | input | 8 | FIFO head byte (first-word fall-through) |
| mac_req | output | 1 | Transmit request to the MAC |
| mac_gnt | input | 1 | Transmit grant from the MAC |
| tx_valid | output | 1 | Byte present on tx_data |
| tx_data | output | 8 | Outgoing frame byte |
| tx_last | output | 1 | Final byte of the frame |

## Verification
The properties assume a few things about the neighbours. The fetch engine raises `fetch_done` only after a `fetch_start` and only once per fetch. The MAC grant is a single-cycle pulse given only while `mac_req` is high. At most one acknowledge is outstanding at a time. The FIFO already holds at least as many bytes as the reported count. The stimulus keeps to all of these. Its fetch model answers one command with one done pulse a few cycles later. Its grant pulse is issued only after `mac_req` has been seen high. Its FIFO model has the payload ready before the fetch completes. Its only out-of-turn inputs are one acknowledge and one read injected during a pending fetch, which is the case the pending slot and the busy refusal exist for.

// File: rtl/rsp_tx_pkg.sv
package rsp_tx_pkg;

    localparam int HDR_BYTES = 14;
    localparam int IDX_W     = 4;
    localparam int VC_W      = 2;
    localparam int SIZE_W    = 16;

    typedef enum logic [7:0] {
        FT_NULL  = 8'h00,
        FT_WRITE = 8'h02,
        FT_ACK   = 8'h05
    } ftype_e;

    localparam logic [3:0] FL_NONE = 4'h0;
    localparam logic [3:0] FL_SOF  = 4'h1;
    localparam logic [3:0] FL_EOF  = 4'h2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAITGNT,
        ST_HDR,
        ST_PAY
    } st_e;

    typedef struct packed {
        logic [15:0]     serial;
        logic [VC_W-1:0] chan;
    } req_t;

    typedef struct packed {
        ftype_e            ftype;
        logic [15:0]       serial;
        logic [VC_W-1:0]   chan;
        logic [3:0]        flags;
        logic [SIZE_W-1:0] size;
    } desc_t;

    // Descriptor for a read response, chosen by the fetch outcome
    function automatic desc_t read_desc(req_t r, logic [SIZE_W-1:0] cnt);
        desc_t d;
        d.serial = r.serial;
        d.chan   = r.chan;
        if (cnt == '0) begin
            d.ftype = FT_NULL;
            d.flags = FL_NONE;
            d.size  = '0;
        end else begin
            d.ftype = FT_WRITE;
            d.flags = FL_SOF | FL_EOF;
            d.size  = cnt;
        end
        return d;
    endfunction

    // One header byte by position
    function automatic logic [7:0] hdr_byte(desc_t d, logic [47:0] host,
                                           logic [15:0] proto, logic [IDX_W-1:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5:
                b = host[8*(5 - int'(idx)) +: 8];
            4'd6:    b = d.serial[15:8];
            4'd7:    b = d.serial[7:0];
            4'd8:    b = d.ftype;
            4'd9:    b = {d.chan, 2'b00, d.flags};
            4'd10:   b = d.size[15:8];
            4'd11:   b = d.size[7:0];
            4'd12:   b = proto[15:8];
            4'd13:   b = proto[7:0];
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/rsp_tx_ack_slot.sv
module rsp_tx_ack_slot
    import rsp_tx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  in_valid,
    input  desc_t in_desc,
    input  logic  take,
    output logic  pend,
    output desc_t pend_desc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend      <= 1'b0;
            pend_desc <= '0;
        end else if (in_valid) begin
            pend      <= 1'b1;
            pend_desc <= in_desc;
        end else if (take) begin
            pend      <= 1'b0;
        end
    end
endmodule

// File: rtl/rsp_tx_hdr_gen.sv
module rsp_tx_hdr_gen
    import rsp_tx_pkg::*;
#(
    parameter logic [47:0] HOST_ADDR = 48'h02_00_00_00_00_01,
    parameter logic [15:0] PROTO     = 16'h88B5
) (
    input  desc_t            desc,
    input  logic [IDX_W-1:0] idx,
    output logic [7:0]       byte_out,
    output logic             at_end
);
    always_comb begin
        byte_out = hdr_byte(desc, HOST_ADDR, PROTO, idx);
        at_end   = (idx == IDX_W'(HDR_BYTES - 1));
    end
endmodule

// File: rtl/rsp_tx_pay_cnt.sv
module rsp_tx_pay_cnt #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] count,
    input  logic             dec,
    output logic             is_last
);
    logic [CNT_W-1:0] rem;

    always_ff @(posedge clk) begin
        if (rst)       rem <= '0;
        else if (load) rem <= count;
        else if (dec)  rem <= rem - 1'b1;
    end

    assign is_last = (rem == CNT_W'(1));
endmodule

// File: rtl/rsp_tx_ctrl.sv
module rsp_tx_ctrl
    import rsp_tx_pkg::*;
#(
    parameter int          CNT_W     = 14,
    parameter logic [47:0] HOST_ADDR = 48'h02_00_00_00_00_01,
    parameter logic [15:0] PROTO     = 16'h88B5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_valid,
    output logic             rd_ready,
    input  logic [15:0]      rd_serial,
    input  logic [1:0]       rd_chan,
    input  logic             ack_valid,
    input  logic [15:0]      ack_serial,
    input  logic [1:0]       ack_chan,
    input  logic [15:0]      ack_size,
    output logic [1:0]       vc_sel,
    output logic             fetch_start,
    input  logic             fetch_done,
    input  logic [CNT_W-1:0] fetch_count,
    output logic             fifo_rd,
    input  logic [7:0]       fifo_data,
    output logic             mac_req,
    input  logic             mac_gnt,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last
);
    st_e              st;
    desc_t            cur;
    req_t             rd_q;
    logic [IDX_W-1:0] idx;

    logic  pend, take, hdr_end, pay_last, accept;
    desc_t pend_desc, ack_desc;
    logic [7:0] hdr_b;

    always_comb begin
        ack_desc.ftype  = FT_ACK;
        ack_desc.serial = ack_serial;
        ack_desc.chan   = ack_chan;
        ack_desc.flags  = FL_NONE;
        ack_desc.size   = ack_size;
    end

    assign take     = (st == ST_IDLE) && pend;
    assign rd_ready = (st == ST_IDLE) && !pend && !ack_valid;
    assign accept   = rd_valid && rd_ready;

    rsp_tx_ack_slot u_ack_slot (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (ack_valid),
        .in_desc   (ack_desc),
        .take      (take),
        .pend      (pend),
        .pend_desc (pend_desc)
    );

    rsp_tx_hdr_gen #(
        .HOST_ADDR (HOST_ADDR),
        .PROTO     (PROTO)
    ) u_hdr_gen (
        .desc     (cur),
        .idx      (idx),
        .byte_out (hdr_b),
        .at_end   (hdr_end)
    );

    rsp_tx_pay_cnt #(
        .CNT_W (CNT_W)
    ) u_pay_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    ((st == ST_FETCH) && fetch_done),
        .count   (fetch_count),
        .dec     (st == ST_PAY),
        .is_last (pay_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_IDLE;
            cur         <= '0;
            rd_q        <= '0;
            idx         <= '0;
            vc_sel      <= '0;
            fetch_start <= 1'b0;
        end else begin
            fetch_start <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (pend) begin
                        cur <= pend_desc;
                        st  <= ST_WAITGNT;
                    end else if (accept) begin
                        rd_q.serial <= rd_serial;
                        rd_q.chan   <= rd_chan;
                        vc_sel      <= rd_chan;
                        fetch_start <= 1'b1;
                        st          <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (fetch_done) begin
                        cur <= read_desc(rd_q, SIZE_W'(fetch_count));
                        st  <= ST_WAITGNT;
                    end
                end
                ST_WAITGNT: begin
                    if (mac_gnt) begin
                        idx <= '0;
                        st  <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (hdr_end) st <= (cur.ftype == FT_WRITE) ? ST_PAY : ST_IDLE;
                    else         idx <= idx + 1'b1;
                end
                ST_PAY: begin
                    if (pay_last) st <= ST_IDLE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mac_req  = (st == ST_WAITGNT);
        tx_valid = (st == ST_HDR) || (st == ST_PAY);
        fifo_rd  = (st == ST_PAY);
        tx_data  = (st == ST_PAY) ? fifo_data : hdr_b;
        tx_last  = ((st == ST_HDR) && hdr_end && (cur.ftype != FT_WRITE))
                || ((st == ST_PAY) && pay_last);
    end
endmodule

// File: rtl/rsp_tx_ctrl_chk.sv
module rsp_tx_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [1:0] rd_chan,
    input logic       ack_valid,
    input logic [1:0] vc_sel,
    input logic       fetch_start,
    input logic       fifo_rd,
    input logic       mac_req,
    input logic       mac_gnt,
    input logic       tx_valid,
    input logic       tx_last
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!tx_valid && !tx_last && !mac_req && !fetch_start && !fifo_rd));

    assert_fetch_launch_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_ready) |=> (fetch_start && vc_sel == $past(rd_chan)));

    assert_fetch_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        fetch_start |=> !fetch_start);

    assert_quiet_fetch_R3: assert property (@(posedge clk) disable iff (rst)
        fetch_start |-> (!mac_req && !tx_valid && !rd_ready));

    assert_hold_request_R4: assert property (@(posedge clk) disable iff (rst)
        (mac_req && !mac_gnt) |=> (mac_req && !tx_valid));

    assert_header_start_R5: assert property (@(posedge clk) disable iff (rst)
        (mac_req && mac_gnt) |=> (tx_valid && !mac_req));

    assert_pop_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> tx_valid);

    assert_ack_blocks_read_R9: assert property (@(posedge clk) disable iff (rst)
        ack_valid |=> !rd_ready);

    assert_last_with_valid_R10: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);
endmodule

bind rsp_tx_ctrl rsp_tx_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .rd_valid    (rd_valid),
    .rd_ready    (rd_ready),
    .rd_chan     (rd_chan),
    .ack_valid   (ack_valid),
    .vc_sel      (vc_sel),
    .fetch_start (fetch_start),
    .fifo_rd     (fifo_rd),
    .mac_req     (mac_req),
    .mac_gnt     (mac_gnt),
    .tx_valid    (tx_valid),
    .tx_last     (tx_last)
);

// File: tb/rsp_tx_ctrl_bench.sv
module rsp_tx_ctrl_bench;
    localparam int          CNT_W = 14;
    localparam logic [47:0] HOST  = 48'hA1_B2_C3_D4_E5_F6;
    localparam logic [15:0] PROT  = 16'h9ABC;

    typedef struct packed {
        logic        is_ack;
        logic [15:0] serial;
        logic [1:0]  chan;
        logic [15:0] cnt;
        logic [7:0]  ety;
        logic [3:0]  efl;
    } vec_t;

    // cnt: fetch count for reads, echoed size for acks
    localparam vec_t VECS [6] = '{
        '{1'b0, 16'h0101, 2'd0, 16'd0,      8'h00, 4'h0},
        '{1'b0, 16'h0202, 2'd1, 16'd5,      8'h02, 4'h3},
        '{1'b0, 16'hBEEF, 2'd3, 16'd1,      8'h02, 4'h3},
        '{1'b1, 16'h1357, 2'd2, 16'h1234,   8'h05, 4'h0},
        '{1'b0, 16'h8000, 2'd2, 16'd40,     8'h02, 4'h3},
        '{1'b1, 16'hFFFF, 2'd0, 16'h0000,   8'h05, 4'h0}
    };

    logic clk = 1'b0, rst = 1'b1;
    logic rd_valid = 0, ack_valid = 0, fetch_done = 0, mac_gnt = 0;
    logic [15:0] rd_serial = 0, ack_serial = 0, ack_size = 0;
    logic [1:0]  rd_chan = 0, ack_chan = 0;
    logic [CNT_W-1:0] fetch_count = 0;
    logic rd_ready, fetch_start, fifo_rd, mac_req, tx_valid, tx_last;
    logic [1:0] vc_sel;
    logic [7:0] fifo_data, tx_data;
    logic fclr = 1'b0;
    logic [7:0] fptr;

    int n_chk = 0, n_fail = 0;
    logic [7:0] cap [0:127];

    always #5 clk = ~clk;

    always @(posedge clk) begin
        if (fclr)         fptr <= 8'd0;
        else if (fifo_rd) fptr <= fptr + 8'd1;
    end
    assign fifo_data = 8'(int'(fptr) * 7 + 3);

    rsp_tx_ctrl #(.CNT_W(CNT_W), .HOST_ADDR(HOST), .PROTO(PROT)) u_rsp_tx_ctrl (
        .clk(clk), .rst(rst),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_serial(rd_serial), .rd_chan(rd_chan),
        .ack_valid(ack_valid), .ack_serial(ack_serial), .ack_chan(ack_chan), .ack_size(ack_size),
        .vc_sel(vc_sel), .fetch_start(fetch_start), .fetch_done(fetch_done), .fetch_count(fetch_count),
        .fifo_rd(fifo_rd), .fifo_data(fifo_data),
        .mac_req(mac_req), .mac_gnt(mac_gnt),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_hdr(int i, logic [15:0] ser, logic [1:0] ch,
                                           logic [7:0] ty, logic [3:0] fl, logic [15:0] sz);
        case (i)
            0: return HOST[47:40];  1: return HOST[39:32];
            2: return HOST[31:24];  3: return HOST[23:16];
            4: return HOST[15:8];   5: return HOST[7:0];
            6: return ser[15:8];    7: return ser[7:0];
            8: return ty;           9: return {ch, 2'b00, fl};
            10: return sz[15:8];    11: return sz[7:0];
            12: return PROT[15:8];  default: return PROT[7:0];
        endcase
    endfunction

    // Grant the pending request, capture the frame and compare it
    task automatic grant_and_check(input logic [15:0] ser, input logic [1:0] ch,
                                   input logic [7:0] ty, input logic [3:0] fl,
                                   input logic [15:0] sz, input int paylen);
        int got = 0, lastpos = -1, nlast = 0, nrd = 0, gaps = 0, hbad = 0, pbad = 0;
        int explen = 14 + paylen;
        bit seen = 0;
        chk(mac_req == 1'b1, "R4 request before grant", int'(mac_req), 1);
        mac_gnt = 1'b1;
        @(negedge clk);
        mac_gnt = 1'b0;
        for (int c = 0; c < 300 && !seen; c++) begin
            if (tx_valid) begin
                cap[got] = tx_data;
                if (tx_last) begin lastpos = got; nlast++; seen = 1; end
                if (fifo_rd) nrd++;
                got++;
            end else if (got > 0) gaps++;
            @(negedge clk);
        end
        for (int i = 0; i < 14; i++)
            if (cap[i] != exp_hdr(i, ser, ch, ty, fl, sz)) hbad++;
        for (int k = 0; k < paylen; k++)
            if (cap[14 + k] != 8'(k * 7 + 3)) pbad++;
        chk(hbad == 0, "R5 header bytes", hbad, 0);
        chk(gaps == 0, "R5 contiguous bytes", gaps, 0);
        chk(cap[8] == ty, (ty == 8'h05) ? "R8 ack type" : (ty == 8'h00 ? "R6 null type" : "R7 write type"),
            int'(cap[8]), int'(ty));
        chk(got == explen, "R7 frame length", got, explen);
        chk(pbad == 0, "R7 payload bytes", pbad, 0);
        chk(nrd == paylen, (paylen == 0) ? "R6 no fifo pop" : "R7 fifo pops", nrd, paylen);
        chk(lastpos == explen - 1 && nlast == 1, "R10 last marker", lastpos, explen - 1);
    endtask

    task automatic run_read(input logic [15:0] ser, input logic [1:0] ch,
                            input logic [15:0] cnt, input logic [7:0] ty,
                            input logic [3:0] fl, input bit inject);
        fclr = 1'b1;
        rd_valid = 1'b1; rd_serial = ser; rd_chan = ch;
        @(negedge clk);
        fclr = 1'b0; rd_valid = 1'b0;
        chk(fetch_start == 1'b1, "R2 fetch command", int'(fetch_start), 1);
        chk(vc_sel == ch, "R2 channel select", int'(vc_sel), int'(ch));
        @(negedge clk);
        chk(fetch_start == 1'b0, "R2 single pulse", int'(fetch_start), 0);
        chk(!mac_req && !tx_valid && !rd_ready, "R3 quiet while fetching",
            int'({mac_req, tx_valid, rd_ready}), 0);
        if (inject) begin
            rd_valid = 1'b1; rd_chan = ~ch;
            ack_valid = 1'b1; ack_serial = 16'hA5A5; ack_chan = ~ch; ack_size = 16'h0777;
            @(negedge clk);
            rd_valid = 1'b0; ack_valid = 1'b0;
            @(negedge clk);
            chk(fetch_start == 1'b0 && vc_sel == ch, "R3 busy read ignored", int'(vc_sel), int'(ch));
            chk(rd_ready == 1'b0, "R9 ready low while ack held", int'(rd_ready), 0);
        end
        fetch_done = 1'b1; fetch_count = CNT_W'(cnt);
        @(negedge clk);
        fetch_done = 1'b0;
        repeat (3) @(negedge clk);
        chk(!tx_valid, "R4 no bytes before grant", int'(tx_valid), 0);
        grant_and_check(ser, ch, ty, fl, (cnt == 0) ? 16'd0 : cnt, int'(cnt));
    endtask

    task automatic run_ack(input logic [15:0] ser, input logic [1:0] ch, input logic [15:0] sz);
        ack_valid = 1'b1; ack_serial = ser; ack_chan = ch; ack_size = sz;
        @(negedge clk);
        ack_valid = 1'b0;
        chk(rd_ready == 1'b0, "R9 ack blocks read", int'(rd_ready), 0);
        @(negedge clk);
        grant_and_check(ser, ch, 8'h05, 4'h0, sz, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!tx_valid && !mac_req && !fetch_start && !fifo_rd && !tx_last, "R1 outputs in reset",
            int'({tx_valid, mac_req, fetch_start, fifo_rd, tx_last}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_ready == 1'b1, "R1 ready after reset", int'(rd_ready), 1);

        foreach (VECS[i]) begin
            if (VECS[i].is_ack) run_ack(VECS[i].serial, VECS[i].chan, VECS[i].cnt);
            else run_read(VECS[i].serial, VECS[i].chan, VECS[i].cnt, VECS[i].ety, VECS[i].efl, 1'b0);
            repeat (2) @(negedge clk);
        end

        // R9: acknowledge arriving mid-read is sent right after the read frame
        run_read(16'h4242, 2'd1, 16'd3, 8'h02, 4'h3, 1'b1);
        chk(mac_req == 1'b0, "R9 ack not before read ends", int'(mac_req), 0);
        @(negedge clk);
        grant_and_check(16'hA5A5, 2'd2, 8'h05, 4'h0, 16'h0777, 0);
        repeat (2) @(negedge clk);

        // R1: reset while waiting for the grant drops the request
        rd_valid = 1'b1; rd_serial = 16'h0BAD; rd_chan = 2'd2;
        @(negedge clk);
        rd_valid = 1'b0;
        fetch_done = 1'b1; fetch_count = CNT_W'(4);
        @(negedge clk);
        fetch_done = 1'b0;
        chk(mac_req == 1'b1, "R4 request raised", int'(mac_req), 1);
        rst = 1'b1;
        @(negedge clk);
        chk(!mac_req && !tx_valid, "R1 reset mid frame", int'({mac_req, tx_valid}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_ready == 1'b1, "R1 ready after reset", int'(rd_ready), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule